// File: doc/BRIEF.md
# Audio Codec Power-Up Configuration Sequencer

This block brings a stereo audio codec out of power-up into a working configuration. It does this over a three-wire serial control bus. It does not drive the bus pins itself. Each register write goes to a separate bus master as one request, which carries an address byte, a payload length of one or two bytes and the payload bytes. The master answers each request with a one-cycle completion pulse. The block also owns the codec's hardware reset pin.

A single-cycle `start` launches the sequence. The block first waits a programmable number of clock cycles while the codec wakes. It then issues the following requests, one at a time:

- two status writes, with a reset pulse on the pin between them;
- a status write that sets power and gain;
- a volume write and a mode write;
- three two-byte extended-register writes covering the mixer, the automatic gain control and the output level.

After the last completion the block raises `done`. It holds `done` until the next `start`.

Top module: `codec_init_seq`

## Requirements
- R1: While reset is held and after it is released, `req`, `codec_rst` and `done` are low until a `start` is seen.
- R2: A `start` sampled while idle or finished begins the sequence. The first `req` is high in the cycle that follows the WAKE_CYCLES-th rising edge after the edge that sampled `start`. A `start` sampled while the sequence is running has no effect on any output.
- R3: The address byte is the device number (5) shifted left by two, ORed with the register type. This gives 8'h16 for status writes (type 2) and 8'h14 for primary data writes (type 0).
- R4: The first request writes status with `req_len`=1 and payload 8'h62. Bit 6 (reset) is 1, bits 5:4 (clock select) are 2 and bits 3:1 (format) are 1. `req_byte1` is 0 whenever `req_len` is 1.
- R5: After the first request completes, `codec_rst` is high for exactly RST_CYCLES cycles, starting the cycle after that completion. It is low again in the cycle in which the second request, status 8'h22 (reset bit cleared), is issued.
- R6: The third request writes status 8'hE3: bit 7 set, bits 1:0 power = 3, bit 5 input gain, bit 6 output gain.
- R7: The fourth and fifth requests are one-byte data writes: volume 8'h0F (6-bit value 15, top bits zero), then mode 8'h83.
- R8: The last three requests have `req_len`=2, with first byte 8'hC0|ext and second byte 8'hE0|value, in this order: (8'hC2, 8'hF2), (8'hC4, 8'hF3), (8'hC6, 8'hE3).
- R9: Each request is a one-cycle `req` pulse. The next `req` comes in the cycle after the edge that samples `bus_done`. A `bus_done` that arrives while no request is outstanding is ignored.
- R10: `done` rises in the cycle after the final `bus_done` and stays high until a `start` is sampled. The sampling edge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the sequence |
| bus_done | input | 1 | One-cycle completion pulse from the bus master |
| req | output | 1 | One-cycle request to the bus master |
| req_addr | output | 8 | Address byte of the request |
| req_len | output | 2 | Number of payload bytes (1 or 2) |
| req_byte0 | output | 8 | First payload byte |
| req_byte1 | output | 8 | Second payload byte, zero for one-byte writes |
| codec_rst | output | 1 | Hardware reset pin of the codec, active high |
| done | output | 1 | Sequence complete, held until the next start |

## Verification
The assertions assume that `start` and `bus_done` are synchronous to `clk`. They also assume that the master answers every request with one completion pulse, which is what makes the rise of `done` trace back to a `bus_done`. The bench's responder returns exactly one pulse per request, after a latency that changes from run to run, zero included. The bench injects stray completion pulses and repeated starts only during the wake-up wait, where nothing is outstanding. This means the ignored-input behaviour is exercised without breaking the one-answer-per-request assumption.

// File: rtl/codec_init_seq.sv
module codec_init_seq #(
  parameter int WAKE_CYCLES = 10_000_000,
  parameter int RST_CYCLES  = 4,
  parameter int DEV_NUM     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bus_done,
  output logic       req,
  output logic [7:0] req_addr,
  output logic [1:0] req_len,
  output logic [7:0] req_byte0,
  output logic [7:0] req_byte1,
  output logic       codec_rst,
  output logic       done
);
  localparam int NSTEPS = 8;
  localparam int SW     = $clog2(NSTEPS);
  localparam int CMAX   = (WAKE_CYCLES > RST_CYCLES) ? WAKE_CYCLES : RST_CYCLES;
  localparam int CW     = $clog2(CMAX + 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYCLES - 1);
  localparam logic [SW-1:0] LAST_STEP = SW'(NSTEPS - 1);

  localparam logic [7:0] A_STAT = 8'((DEV_NUM << 2) | 2);
  localparam logic [7:0] A_DAT0 = 8'((DEV_NUM << 2) | 0);

  localparam logic [7:0] ST0_BASE = 8'((2 << 4) | (1 << 1));
  localparam logic [7:0] ST0_RST  = ST0_BASE | 8'h40;
  localparam logic [7:0] ST1_VAL  = 8'h80 | 8'h40 | 8'h20 | 8'h03;
  localparam logic [7:0] VOL_VAL  = 8'(15 & 6'h3f);
  localparam logic [7:0] MODE_VAL = 8'h80 | 8'h03;

  function automatic logic [7:0] ext_a(input int ea);
    return 8'hC0 | 8'(ea);
  endfunction
  function automatic logic [7:0] ext_v(input int v);
    return 8'hE0 | 8'(v);
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_ISSUE, S_WAIT, S_RST, S_FIN} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [SW-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      step  <= '0;
    end else begin
      case (state)
        S_IDLE, S_FIN: if (start) begin
          state <= S_WAKE;
          cnt   <= '0;
          step  <= '0;
        end
        S_WAKE: if (cnt == WAKE_LAST) state <= S_ISSUE;
                else cnt <= cnt + 1'b1;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (bus_done) begin
          if (step == '0) begin
            state <= S_RST;
            cnt   <= '0;
            step  <= step + 1'b1;
          end else if (step == LAST_STEP) begin
            state <= S_FIN;
          end else begin
            state <= S_ISSUE;
            step  <= step + 1'b1;
          end
        end
        S_RST: if (cnt == RST_LAST) state <= S_ISSUE;
               else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_addr  = A_DAT0;
    req_len   = 2'd1;
    req_byte0 = 8'h00;
    req_byte1 = 8'h00;
    case (step)
      3'd0: begin req_addr = A_STAT; req_byte0 = ST0_RST;  end
      3'd1: begin req_addr = A_STAT; req_byte0 = ST0_BASE; end
      3'd2: begin req_addr = A_STAT; req_byte0 = ST1_VAL;  end
      3'd3: req_byte0 = VOL_VAL;
      3'd4: req_byte0 = MODE_VAL;
      3'd5: begin req_len = 2'd2; req_byte0 = ext_a(2); req_byte1 = ext_v(2 | (4 << 2)); end
      3'd6: begin req_len = 2'd2; req_byte0 = ext_a(4); req_byte1 = ext_v((1 << 4) | 3); end
      default: begin req_len = 2'd2; req_byte0 = ext_a(6); req_byte1 = ext_v((0 << 2) | 3); end
    endcase
  end

  assign req       = (state == S_ISSUE);
  assign codec_rst = (state == S_RST);
  assign done      = (state == S_FIN);
endmodule

// File: rtl/codec_init_seq_chk.sv
module codec_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       bus_done,
  input logic       req,
  input logic [7:0] req_addr,
  input logic [1:0] req_len,
  input logic [7:0] req_byte0,
  input logic [7:0] req_byte1,
  input logic       codec_rst,
  input logic       done
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) req |=> !req); // R9
  AST_ADDR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_addr == 8'h16 || req_addr == 8'h14)); // R3
  AST_EXT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_len == 2'd2) |-> (req_byte0[7:6] == 2'b11 && req_byte1[7:5] == 3'b111)); // R8
  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req && req_len == 2'd1) |-> req_byte1 == 8'h00); // R4
  AST_RST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) codec_rst |-> !req); // R5
  AST_RST_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codec_rst) |-> $past(bus_done)); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_done)); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req && !codec_rst)); // R10
endmodule

bind codec_init_seq codec_init_seq_chk u_chk (.*);

// File: tb/tb_codec_init_seq.sv
module tb_codec_init_seq;
  localparam int WAKE = 20;
  localparam int RSTC = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic rsp_done = 0, stray = 0;
  logic bus_done;
  logic req, codec_rst, done;
  logic [7:0] req_addr, req_byte0, req_byte1;
  logic [1:0] req_len;
  int checks = 0, errors = 0, cycles = 0;

  assign bus_done = rsp_done | stray;
  always #5 clk = ~clk;

  codec_init_seq #(.WAKE_CYCLES(WAKE), .RST_CYCLES(RSTC), .DEV_NUM(5)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_done(bus_done),
    .req(req), .req_addr(req_addr), .req_len(req_len),
    .req_byte0(req_byte0), .req_byte1(req_byte1),
    .codec_rst(codec_rst), .done(done));

  // Reference model: phases 0 idle, 1 wake, 2 request, 3 waiting, 4 reset pulse, 5 finished
  logic [25:0] q[$];
  int ph = 0, left = 0, nsent = 0;
  logic m_req, m_rst, m_done;
  logic [25:0] cur;
  assign m_req  = (ph == 2);
  assign m_rst  = (ph == 4);
  assign m_done = (ph == 5);

  function automatic logic [25:0] tx(input int len, input int a, input int b0, input int b1);
    return {2'(len), 8'(a), 8'(b0), 8'(b1)};
  endfunction

  function automatic string tag_of(input int n);
    case (n)
      0: return "R4";  1: return "R5";  2: return "R6";
      3, 4: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; q = {}; nsent = 0;
    end else begin
      case (ph)
        0, 5: if (start) begin
          q = {};
          q.push_back(tx(1, 8'h16, 8'h62, 0));
          q.push_back(tx(1, 8'h16, 8'h22, 0));
          q.push_back(tx(1, 8'h16, 8'hE3, 0));
          q.push_back(tx(1, 8'h14, 8'h0F, 0));
          q.push_back(tx(1, 8'h14, 8'h83, 0));
          q.push_back(tx(2, 8'h14, 8'hC2, 8'hF2));
          q.push_back(tx(2, 8'h14, 8'hC4, 8'hF3));
          q.push_back(tx(2, 8'h14, 8'hC6, 8'hE3));
          nsent = 0; left = WAKE; ph = 1;
        end
        1: begin left--; if (left == 0) ph = 2; end
        2: ph = 3;
        3: if (bus_done) begin
          void'(q.pop_front());
          nsent++;
          if (nsent == 1) begin ph = 4; left = RSTC; end
          else if (q.size() == 0) ph = 5;
          else ph = 2;
        end
        4: begin left--; if (left == 0) ph = 2; end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk("R2/R9", "req", int'(req), int'(m_req));
    chk("R5", "codec_rst", int'(codec_rst), int'(m_rst));
    chk("R10", "done", int'(done), int'(m_done));
    if (m_req && q.size() > 0) begin
      cur = q[0];
      chk("R3", "req_addr", int'(req_addr), int'(cur[23:16]));
      chk(tag_of(nsent), "req_len", int'(req_len), int'(cur[25:24]));
      chk(tag_of(nsent), "req_byte0", int'(req_byte0), int'(cur[15:8]));
      chk(tag_of(nsent), "req_byte1", int'(req_byte1), int'(cur[7:0]));
    end
  end

  // bus master stand-in: one completion per request after lat cycles
  int lat = 2, wn = 0;
  bit pend = 0;
  always @(negedge clk) begin
    rsp_done <= 0;
    if (pend) begin
      if (wn == 0) begin rsp_done <= 1; pend = 0; end
      else wn--;
    end else if (req) begin
      pend = 1; wn = lat;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    chk("R1", "req in reset", int'(req), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1;
    cyc(4);
    chk("R1", "idle codec_rst", int'(codec_rst), 0);
    chk("R1", "idle done", int'(done), 0);

    lat = 2;
    pulse_start();
    cyc(3);
    stray = 1; @(negedge clk); stray = 0;   // R9: ignored while nothing outstanding
    cyc(2);
    pulse_start();                          // R2: ignored while running
    wait_done();
    cyc(6);
    chk("R10", "done held", int'(done), 1);

    lat = 0;
    pulse_start();
    chk("R10", "done cleared by start", int'(done), 0);
    wait_done();
    cyc(2);

    lat = 5;
    pulse_start();
    cyc(8);
    stray = 1; @(negedge clk); stray = 0;
    wait_done();
    cyc(3);
    chk("R10", "final done", int'(done), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule